// File: doc/BRIEF.md
# APB Down-Counting Reload Timer

This block is a 32-bit down-counter that sits behind a zero-wait-state APB slave port. Software programs a reload value and a control word. The counter then steps down once per count tick. When it steps from 1 to 0, it can latch a sticky interrupt flag, and that flag drives a level interrupt line. After the 1-to-0 step the counter stays at zero for one tick and then reloads. A reload value of zero therefore parks the counter at zero, and no further events follow.

Ticks come from one of three sources, chosen by the control word:
- every bus clock;
- every bus clock while a synchronized external input is high;
- each rising edge of that external input.

The external input passes through a two-flop synchronizer before it is used. A small window of read-only identification words sits near the top of the 4 KB address window. All other offsets read as zero and ignore writes.

Top module: `apb_reload_timer`

## Requirements
- R1: After reset, the control, count, reload and status registers all read 0, `timer_irq` is low and the counter does not move.
- R2: The control register at offset 0x0 keeps only bits [3:0]: bit 0 run, bit 1 gate by external input, bit 2 count on external rising edges, bit 3 interrupt enable. Bits above 3 read as 0.
- R3: With run set, the count at offset 0x4 drops by one per tick. With bits 1 and 2 both clear, a tick is every bus clock. With bit 1 set, a tick is every bus clock in which the synchronized input is high. With bit 2 set, a tick is each synchronized rising edge. With run clear, the count does not change.
- R4: A tick taken at count 1 gives 0 and is the expiry event. A tick taken at count 0 loads the reload value, so the counter rests at zero for exactly one tick.
- R5: When the reload value is 0, the counter stays at 0 through any number of ticks, and no expiry happens.
- R6: A write to the reload register at offset 0x8 sets both the reload value and the live count. A write to offset 0x4 sets only the live count. A load takes priority over a tick in the same cycle.
- R7: Status bit 0 at offset 0xC is set at an expiry only when control bit 3 is 1. Writing 1 to it clears it, and writing 0 leaves it alone. A set in the same cycle as a clear wins. `timer_irq` equals this bit.
- R8: Offsets 0xFD0 to 0xFFC read, in rising address order, 0x04, 0x00, 0x00, 0x00, 0x22, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Writes to them are ignored.
- R9: Reads of any other offset return 0. Writes to any other offset change no register.
- R10: `pready` is always 1 and `pslverr` always 0. A register write takes effect at the clock edge that ends the access phase (psel, penable and pwrite all high).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and count clock |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 12 | Byte offset within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from paddr |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| ext_in | input | 1 | External count gate or count clock |
| timer_irq | output | 1 | Level interrupt, equal to status bit 0 |

## Verification
The bench counts ticks exactly, because the gate and edge modes let it control how many ticks reach the counter. This lets it pin down the resting cycle at zero. A design that reloads directly at 1 would read one step lower after the wrap. A design that skips the rest cycle would lose a tick on every wrap. With a zero reload, a design that raises an event on every tick at zero shows a flag that should be clear. The bench also checks that a write of 0 to the status register does not clear the flag, that a reload write also loads the live count, and that the identification words and unmapped offsets neither change nor disturb other registers.

// File: rtl/tmr_pkg.sv
// Shared constants, control-word layout and identification values for the
// APB reload timer. Assumes a 12-bit byte offset and 32-bit data words.
package tmr_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int CTRL_W = 4;
    localparam int ID_WORDS = 12;

    localparam logic [ADDR_W-1:0] OFF_CTRL   = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_COUNT  = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_RELOAD = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_STATUS = 12'h00C;
    localparam logic [ADDR_W-1:0] OFF_ID_LO  = 12'hFD0;
    localparam logic [ADDR_W-1:0] OFF_ID_HI  = 12'hFFC;

    // Control word; member order maps bit 3 down to bit 0.
    typedef struct packed {
        logic irq_en;    // bit 3
        logic edge_clk;  // bit 2
        logic gate;      // bit 1
        logic run;       // bit 0
    } ctrl_t;

    // Identification byte for word index 0..11 (rising address order).
    function automatic logic [7:0] id_byte(input logic [3:0] idx);
        logic [7:0] v;
        case (idx)
            4'd0:    v = 8'h04;
            4'd4:    v = 8'h22;
            4'd5:    v = 8'hB8;
            4'd6:    v = 8'h1B;
            4'd8:    v = 8'h0D;
            4'd9:    v = 8'hF0;
            4'd10:   v = 8'h05;
            4'd11:   v = 8'hB1;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/tmr_ext_qual.sv
// External input qualifier: synchronizes ext_in through SYNC_STAGES flops
// and forms the count tick from the selected source (every clock, gated by
// the synchronized level, or one pulse per synchronized rising edge).
// Assumes SYNC_STAGES >= 2 and ext_in slow relative to clk in edge mode.
module tmr_ext_qual #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    input  logic run,
    input  logic gate_sel,
    input  logic edge_sel,
    output logic tick
);

    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] sync_q;
    logic         prev_q;
    logic         ext_lvl;
    logic         rise;
    logic         src_tick;
    logic         gate_ok;

    // Synchronizer chain plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[TOP-1:0], ext_in};
            prev_q <= sync_q[TOP];
        end
    end

    // Tick selection from the synchronized level.
    always_comb begin
        ext_lvl  = sync_q[TOP];
        rise     = ext_lvl & ~prev_q;
        src_tick = edge_sel ? rise : 1'b1;
        gate_ok  = gate_sel ? ext_lvl : 1'b1;
        tick     = run & src_tick & gate_ok;
    end

    // R3: in edge mode a tick never lasts two consecutive cycles.
    p_edge_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel && tick) |=> !(edge_sel && tick));

endmodule

// File: rtl/tmr_down_counter.sv
// Down-counter with the rest-at-zero reload sequence: 1 -> 0 is expiry,
// a tick at 0 loads the reload value. A load from the bus wins over a tick.
module tmr_down_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Counter state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load_en) begin
            count <= load_val;
        end else if (tick) begin
            if (count == '0) count <= reload_val;
            else             count <= count - ONE;
        end
    end

    // Expiry strobe for the step from 1 to 0.
    always_comb begin
        expire = tick & ~load_en & (count == ONE);
    end

    // R4: after an expiry the counter sits at zero.
    p_expire_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (count == '0));

    // R4: a tick at zero brings in the reload value.
    p_dwell_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_en && count == '0) |=> (count == $past(reload_val)));

    // R5: zero count with zero reload stays at zero without a load.
    p_zero_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && reload_val == '0 && !load_en) |=> (count == '0));

    // R6: a bus load is taken even when a tick coincides.
    p_load_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (count == $past(load_val)));

endmodule

// File: rtl/tmr_apb_regs.sv
// APB register file: control word, reload value, sticky status flag,
// read mux with identification words. Zero wait states; writes commit
// at the end of the access phase. Assumes CNT_W <= DATA_W.
module tmr_apb_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              expire,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  reload_val,
    output logic              load_en,
    output logic [CNT_W-1:0]  load_val,
    output logic              irq_flag
);

    logic              wr;
    logic              hit_ctrl, hit_count, hit_reload, hit_status, hit_id;
    logic [ADDR_W-1:0] id_off;
    logic              irq_en_w;

    // Address decode and write strobe.
    always_comb begin
        wr         = psel & penable & pwrite;
        hit_ctrl   = (paddr == OFF_CTRL);
        hit_count  = (paddr == OFF_COUNT);
        hit_reload = (paddr == OFF_RELOAD);
        hit_status = (paddr == OFF_STATUS);
        hit_id     = (paddr >= OFF_ID_LO) && (paddr <= OFF_ID_HI) && (paddr[1:0] == 2'b00);
        id_off     = paddr - OFF_ID_LO;
        load_en    = wr & (hit_count | hit_reload);
        load_val   = pwdata[CNT_W-1:0];
        irq_en_w   = ctrl.irq_en;
    end

    // Control and reload storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl       <= '0;
            reload_val <= '0;
        end else begin
            if (wr && hit_ctrl)   ctrl       <= ctrl_t'(pwdata[CTRL_W-1:0]);
            if (wr && hit_reload) reload_val <= pwdata[CNT_W-1:0];
        end
    end

    // Sticky interrupt flag; set has priority over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                             irq_flag <= 1'b0;
        else if (expire && irq_en_w)            irq_flag <= 1'b1;
        else if (wr && hit_status && pwdata[0]) irq_flag <= 1'b0;
    end

    // Read data mux.
    always_comb begin
        prdata = '0;
        if (hit_ctrl)        prdata = DATA_W'(ctrl);
        else if (hit_count)  prdata = DATA_W'(count);
        else if (hit_reload) prdata = DATA_W'(reload_val);
        else if (hit_status) prdata = DATA_W'(irq_flag);
        else if (hit_id)     prdata = DATA_W'(id_byte(id_off[5:2]));
    end

    // R7: the flag only rises from an expiry with interrupts enabled.
    p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> ($past(expire) && $past(irq_en_w)));

    // R7: a write of one to the status clears it unless a new event lands.
    p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_status && pwdata[0] && !expire) |=> !irq_flag);

    // R2: a control write keeps the low four data bits.
    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && hit_ctrl) |=> (DATA_W'(ctrl) == DATA_W'($past(pwdata[CTRL_W-1:0]))));

endmodule

// File: rtl/apb_reload_timer.sv
// Top of the APB reload timer: joins the register file, the external
// input qualifier and the down-counter. Zero wait states, no error replies.
module apb_reload_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              ext_in,
    output logic              timer_irq
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] load_val;
    logic             load_en;
    logic             expire;
    logic             tick;
    logic             irq_flag;

    tmr_apb_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (pclk),
        .rst_n      (presetn),
        .psel       (psel),
        .penable    (penable),
        .pwrite     (pwrite),
        .paddr      (paddr),
        .pwdata     (pwdata),
        .prdata     (prdata),
        .count      (count),
        .expire     (expire),
        .ctrl       (ctrl),
        .reload_val (reload_val),
        .load_en    (load_en),
        .load_val   (load_val),
        .irq_flag   (irq_flag)
    );

    tmr_ext_qual #(.SYNC_STAGES(SYNC_STAGES)) u_qual (
        .clk      (pclk),
        .rst_n    (presetn),
        .ext_in   (ext_in),
        .run      (ctrl.run),
        .gate_sel (ctrl.gate),
        .edge_sel (ctrl.edge_clk),
        .tick     (tick)
    );

    tmr_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (pclk),
        .rst_n      (presetn),
        .tick       (tick),
        .load_en    (load_en),
        .load_val   (load_val),
        .reload_val (reload_val),
        .count      (count),
        .expire     (expire)
    );

    // Fixed bus response and interrupt level.
    always_comb begin
        pready    = 1'b1;
        pslverr   = 1'b0;
        timer_irq = irq_flag;
    end

    // R1: nothing moves while run is clear and no bus load happens.
    p_idle_stable_r1: assert property (@(posedge pclk) disable iff (!presetn)
        (!ctrl.run && !load_en) |=> $stable(count));

endmodule

// File: tb/apb_reload_timer_bench.sv
module apb_reload_timer_bench;

    logic        pclk = 1'b0;
    logic        presetn;
    logic        psel, penable, pwrite;
    logic [11:0] paddr;
    logic [31:0] pwdata;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic        ext_in;
    logic        timer_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 pclk = ~pclk;

    apb_reload_timer u_apb_reload_timer (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .ext_in(ext_in), .timer_irq(timer_irq)
    );

    // Vector table: mode (0 gate, 1 edge), reload, ticks, expected count, expected flag.
    localparam int NV = 10;
    localparam int V_MODE [NV] = '{0, 0, 0, 0, 1, 1, 0, 0, 1, 0};
    localparam int V_REL  [NV] = '{5, 5, 5, 5, 4, 4, 0, 1, 1, 1};
    localparam int V_TCK  [NV] = '{3, 5, 6, 7, 2, 5, 3, 1, 2, 3};
    localparam int V_CNT  [NV] = '{2, 0, 5, 4, 2, 4, 0, 0, 1, 0};
    localparam int V_IRQ  [NV] = '{0, 1, 1, 1, 0, 1, 0, 1, 1, 1};

    localparam logic [7:0] ID_EXP [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h22, 8'hB8,
                                           8'h1B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge pclk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
    endtask

    // Hold ext_in high for n bus clocks (n gated ticks), then settle.
    task automatic gate_ticks(input int n);
        if (n > 0) begin
            @(negedge pclk); ext_in = 1'b1;
            repeat (n) @(negedge pclk);
            ext_in = 1'b0;
        end
        repeat (5) @(negedge pclk);
    endtask

    // Give n rising edges on ext_in, then settle.
    task automatic edge_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge pclk); ext_in = 1'b1;
            repeat (2) @(negedge pclk);
            ext_in = 1'b0;
            repeat (2) @(negedge pclk);
        end
        repeat (5) @(negedge pclk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge pclk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd, a0, b0;
        psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0; ext_in = 0;
        presetn = 1'b0;
        repeat (4) @(negedge pclk);
        presetn = 1'b1;

        // R1 / R10: reset state and fixed response.
        apb_read(12'h000, rd); check("R1 ctrl reset", rd, 0);
        apb_read(12'h004, rd); check("R1 count reset", rd, 0);
        apb_read(12'h008, rd); check("R1 reload reset", rd, 0);
        apb_read(12'h00C, rd); check("R1 status reset", rd, 0);
        check("R1 irq reset", {31'b0, timer_irq}, 0);
        check("R10 pready", {31'b0, pready}, 1);
        check("R10 pslverr", {31'b0, pslverr}, 0);

        // R3 / R4 / R5 / R7: vector table.
        for (int v = 0; v < NV; v++) begin
            apb_write(12'h000, 32'h0);
            apb_write(12'h00C, 32'h1);
            apb_write(12'h008, V_REL[v]);
            apb_write(12'h000, (V_MODE[v] == 1) ? 32'hD : 32'hB);
            if (V_MODE[v] == 1) edge_ticks(V_TCK[v]);
            else                gate_ticks(V_TCK[v]);
            apb_read(12'h004, rd);
            check($sformatf("R3/R4/R5 vector %0d count", v), rd, V_CNT[v]);
            apb_read(12'h00C, rd);
            check($sformatf("R7 vector %0d flag", v), rd, V_IRQ[v]);
            check($sformatf("R7 vector %0d irq pin", v), {31'b0, timer_irq}, V_IRQ[v]);
        end

        // R2: only four control bits kept.
        apb_write(12'h000, 32'hFFFF_FFF2);
        apb_read(12'h000, rd); check("R2 ctrl upper bits", rd, 32'h2);
        apb_write(12'h000, 32'h0);
        apb_write(12'h00C, 32'h1);

        // R6: reload write loads count; count write leaves reload.
        apb_write(12'h008, 32'h1234);
        apb_read(12'h004, rd); check("R6 reload loads count", rd, 32'h1234);
        apb_write(12'h004, 32'h55);
        apb_read(12'h004, rd); check("R6 count write", rd, 32'h55);
        apb_read(12'h008, rd); check("R6 reload untouched", rd, 32'h1234);

        // R3: run clear blocks counting.
        apb_write(12'h000, 32'h2);
        gate_ticks(5);
        apb_read(12'h004, rd); check("R3 run clear holds", rd, 32'h55);

        // R3: free-running mode decrements.
        apb_write(12'h008, 32'd1000);
        apb_write(12'h000, 32'h1);
        apb_read(12'h004, a0);
        apb_read(12'h004, b0);
        check("R3 free run falls", {31'b0, (b0 < a0)}, 1);
        apb_write(12'h000, 32'h0);

        // R7: no flag when interrupt enable is clear.
        apb_write(12'h008, 32'd2);
        apb_write(12'h000, 32'h3);
        gate_ticks(2);
        apb_read(12'h004, rd); check("R7 no-enable count", rd, 0);
        apb_read(12'h00C, rd); check("R7 no-enable flag", rd, 0);

        // R7: write-zero keeps, write-one clears.
        apb_write(12'h008, 32'd1);
        apb_write(12'h000, 32'hB);
        gate_ticks(1);
        apb_write(12'h000, 32'h0);
        apb_write(12'h00C, 32'h0);
        apb_read(12'h00C, rd); check("R7 write zero keeps", rd, 1);
        apb_write(12'h00C, 32'h1);
        apb_read(12'h00C, rd); check("R7 write one clears", rd, 0);
        check("R7 irq pin cleared", {31'b0, timer_irq}, 0);

        // R6 / R5: count write restarts from rest at zero with zero reload.
        apb_write(12'h008, 32'd0);
        apb_write(12'h000, 32'hB);
        apb_write(12'h004, 32'd3);
        gate_ticks(3);
        apb_read(12'h004, rd); check("R6 restart count", rd, 0);
        apb_read(12'h00C, rd); check("R6 restart flag", rd, 1);
        apb_write(12'h00C, 32'h1);
        gate_ticks(4);
        apb_read(12'h004, rd); check("R5 zero reload holds", rd, 0);
        apb_read(12'h00C, rd); check("R5 no second event", rd, 0);
        apb_write(12'h000, 32'h0);

        // R8: identification words and write immunity.
        for (int k = 0; k < 12; k++) begin
            apb_read(12'hFD0 + 12'(k * 4), rd);
            check($sformatf("R8 id word %0d", k), rd, {24'b0, ID_EXP[k]});
        end
        apb_write(12'hFE0, 32'hFFFF_FFFF);
        apb_read(12'hFE0, rd); check("R8 id write ignored", rd, 32'h22);

        // R9: unmapped offsets.
        apb_write(12'h008, 32'h77);
        apb_read(12'h010, rd); check("R9 unmapped read", rd, 0);
        apb_read(12'h800, rd); check("R9 unmapped read high", rd, 0);
        apb_write(12'h010, 32'hFFFF_FFFF);
        apb_write(12'h800, 32'hFFFF_FFFF);
        apb_read(12'h000, rd); check("R9 ctrl unchanged", rd, 0);
        apb_read(12'h008, rd); check("R9 reload unchanged", rd, 32'h77);
        apb_read(12'h004, rd); check("R9 count unchanged", rd, 32'h77);
        apb_read(12'h00C, rd); check("R9 status unchanged", rd, 0);

        finish_run();
    end

endmodule